// File: doc/BRIEF.md
# Mode-Sequenced Calculator Input Controller

This block is the main sequencer of a three-mode financial calculator front panel. It reads ten slide switches and four push buttons. The user first picks an operating mode. The block then walks through the operand entry steps for future value, present value, interest rate and years, and passes straight through any step the chosen mode does not use. Each step is left only when button 3 is pressed together with the one switch that belongs to that step, so a button held by a human for many clock cycles cannot skip several steps.

Operands are assembled from switch-sized slices that three buttons load. After the last operand, the block lowers the start line of the selected compute unit for one cycle and then raises it again. From then on it passes the returned result digits to the display and lights a decimal-point marker. Pressing all four buttons while switch 9 is off returns the panel to its initial state and raises a system-wide reset line. In the entry steps the display shows a four-digit prompt. Right after a load it shows the digits that come back from the result path, for a programmable number of cycles. While the external error flag is high, it shows those returned digits in place of the prompt.

Top module: `calc_seq_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after any clock edge that samples all four keys high with sw_i[9] low, the block is in its clear state: sys_rst_o=1, fv_o=0, pv_o=0, rate_o=1, years_o=1, mode_o=2'b11, all three start lines high, every display digit 127, led_mode_o=000 and led_dp_o=0. All four keys high with sw_i[9] high has no effect.
- R2: One edge after the clear state the block enters the ready state. sys_rst_o is 0 and the display shows 22,0,13,14 (digit 1 is disp_o[27:21], digit 4 is disp_o[6:0]). Key 0 loads sw_i[1:0] into mode_o. Key 3 with sw_i[9] moves to the future-value step.
- R3: led_mode_o is 001 for mode 00, 010 for mode 01, 100 for mode 10 and 000 for mode 11.
- R4: The entry steps run in the order future value, present value, rate, years. Key 3 with sw_i[8], sw_i[7], sw_i[6] and sw_i[5] respectively moves to the next step. The prompts are 8,37,15,30 / 7,37,25,30 / 6,37,18,23 / 5,37,34,27.
- R5: The future-value step is used only in mode 00. Present value and years are used in modes 00 and 01, and rate in modes 01 and 10. An unused step shows its prompt for exactly one cycle and then moves on.
- R6: In the future- and present-value steps, key 0 loads sw_i[9:0] into bits 9:0, key 1 loads sw_i[9:0] into bits 19:10, and key 2 loads sw_i[6:0] into bits 26:20 of the 27-bit operand.
- R7: In the rate step key 0 loads sw_i[6:0] into rate_o. In the years step key 0 loads sw_i[5:0] into years_o. Keys 1 and 2 have no effect in those steps.
- R8: A load moves the block to a show state that displays res_dig_i. The block returns to the entry step SHOW_CYC cycles after the last cycle with a load. Key 3 and the switches do not advance it while it is showing.
- R9: In an entry step with err_i high, the display carries res_dig_i instead of the prompt.
- R10: After the last step, the start line of the selected unit (mode 00: start_rate_o, mode 01: start_fv_o, mode 10: start_dt_o) is low for exactly one cycle and then high. The other two stay high.
- R11: After the launch the block shows res_dig_i with led_dp_o=1 and stays there until a reset.
- R12: With mode 11 the launch pulses no start line and the block returns to the ready state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_i | input | 10 | Slide switches |
| key_i | input | 4 | Push buttons, 1 = pressed |
| err_i | input | 1 | Operand error flag from the external checker |
| res_dig_i | input | 28 | Four 7-bit digit codes from the result multiplexer |
| mode_o | output | 2 | Selected mode |
| fv_o | output | 27 | Future-value operand |
| pv_o | output | 27 | Present-value operand |
| rate_o | output | 7 | Interest operand |
| years_o | output | 6 | Years operand |
| sys_rst_o | output | 1 | System-wide reset |
| start_fv_o | output | 1 | Start line of the future-value unit |
| start_dt_o | output | 1 | Start line of the doubling-time unit |
| start_rate_o | output | 1 | Start line of the rate unit |
| led_mode_o | output | 3 | One-hot mode indicator |
| led_dp_o | output | 1 | Decimal-point marker in the result state |
| disp_o | output | 28 | Four 7-bit digit codes to the segment decoder |

## Verification
State changes, operand loads and the start lines are all registered. Each of them is therefore visible one clock edge after the inputs that cause it, and the display, which decodes the registered state, follows in the same cycle. The bench drives inputs on the falling edge and samples one step after the next rising edge, so each row of the stimulus table describes exactly one edge. The show-state countdown is checked with row-by-row expectations: the block shows res_dig_i for SHOW_CYC cycles after the last load and then shows the prompt. Pass-through steps and the one-cycle start pulse are checked at every single edge.

// File: rtl/calc_seq_pkg.sv
package calc_seq_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_RDY,
    ST_CFV, ST_SFV, ST_CPV, ST_SPV,
    ST_CRT, ST_SRT, ST_CYR, ST_SYR,
    ST_GLO, ST_GHI, ST_RES
  } cst_e;

  typedef logic [1:0] mode_t;
  localparam mode_t M_RATE = 2'd0;
  localparam mode_t M_FV   = 2'd1;
  localparam mode_t M_DT   = 2'd2;
  localparam mode_t M_NONE = 2'd3;

  localparam int DIGW = 7;
  localparam logic [DIGW-1:0] C_BLANK = 7'd127;
  localparam logic [DIGW-1:0] C_DASH  = 7'd37;

  // four-digit prompt per state, digit 1 in the top slot
  function automatic logic [4*DIGW-1:0] prompt(cst_e s);
    case (s)
      ST_RDY:  prompt = {7'd22, 7'd0, 7'd13, 7'd14};
      ST_CFV:  prompt = {7'd8, C_DASH, 7'd15, 7'd30};
      ST_CPV:  prompt = {7'd7, C_DASH, 7'd25, 7'd30};
      ST_CRT:  prompt = {7'd6, C_DASH, 7'd18, 7'd23};
      ST_CYR:  prompt = {7'd5, C_DASH, 7'd34, 7'd27};
      default: prompt = {4{C_BLANK}};
    endcase
  endfunction

  // does the entry step belong to the mode's operand set
  function automatic logic needed(cst_e s, mode_t m);
    case (s)
      ST_CFV:  needed = (m == M_RATE);
      ST_CPV:  needed = (m == M_RATE) || (m == M_FV);
      ST_CRT:  needed = (m == M_FV) || (m == M_DT);
      ST_CYR:  needed = (m == M_RATE) || (m == M_FV);
      default: needed = 1'b1;
    endcase
  endfunction

  function automatic cst_e next_step(cst_e s);
    case (s)
      ST_CFV:  next_step = ST_CPV;
      ST_CPV:  next_step = ST_CRT;
      ST_CRT:  next_step = ST_CYR;
      default: next_step = ST_GLO;
    endcase
  endfunction

  function automatic cst_e show_of(cst_e s);
    case (s)
      ST_CFV:  show_of = ST_SFV;
      ST_CPV:  show_of = ST_SPV;
      ST_CRT:  show_of = ST_SRT;
      default: show_of = ST_SYR;
    endcase
  endfunction

  function automatic cst_e entry_of(cst_e s);
    case (s)
      ST_SFV:  entry_of = ST_CFV;
      ST_SPV:  entry_of = ST_CPV;
      ST_SRT:  entry_of = ST_CRT;
      default: entry_of = ST_CYR;
    endcase
  endfunction

endpackage

// File: rtl/calc_seq_fsm.sv
module calc_seq_fsm
  import calc_seq_pkg::*;
#(
  parameter int SWW      = 10,
  parameter int SHOW_CYC = 25_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SWW-1:0] sw,
  input  logic [3:0]     key,
  input  mode_t          mode,
  output cst_e           state_q,
  output cst_e           state_d,
  output logic           ld_en,
  output logic           chord
);

  localparam int TW = (SHOW_CYC > 1) ? $clog2(SHOW_CYC) : 1;
  localparam logic [TW-1:0] TRELOAD = TW'(SHOW_CYC - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          wide_ld, narrow_ld, raw_ld, need, adv;

  always_comb begin
    chord     = (&key) & ~sw[SWW-1];
    wide_ld   = (state_q inside {ST_CFV, ST_SFV, ST_CPV, ST_SPV}) & (|key[2:0]);
    narrow_ld = (state_q inside {ST_CRT, ST_SRT, ST_CYR, ST_SYR, ST_RDY}) & key[0];
    raw_ld    = wide_ld | narrow_ld;
    need      = needed(state_q, mode);
    ld_en     = raw_ld & need & ~chord;
    case (state_q)
      ST_CFV:  adv = key[3] & sw[8];
      ST_CPV:  adv = key[3] & sw[7];
      ST_CRT:  adv = key[3] & sw[6];
      ST_CYR:  adv = key[3] & sw[5];
      default: adv = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    case (state_q)
      ST_RST: state_d = ST_RDY;
      ST_RDY: if (key[3] && sw[9]) state_d = ST_CFV;
      ST_CFV, ST_CPV, ST_CRT, ST_CYR: begin
        if (!need) begin
          state_d = next_step(state_q);
        end else if (ld_en) begin
          state_d = show_of(state_q);
          tmr_d   = TRELOAD;
        end else if (adv) begin
          state_d = next_step(state_q);
        end
      end
      ST_SFV, ST_SPV, ST_SRT, ST_SYR: begin
        if (ld_en)              tmr_d   = TRELOAD;
        else if (tmr_q == '0)   state_d = entry_of(state_q);
        else                    tmr_d   = tmr_q - TW'(1);
      end
      ST_GLO:  state_d = (mode == M_NONE) ? ST_RDY : ST_GHI;
      ST_GHI:  state_d = ST_RES;
      default: state_d = ST_RES;
    endcase
    if (chord) state_d = ST_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  // R5: a future-value step outside mode 00 lasts one cycle
  a_r5_skip_fv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFV && mode != M_RATE && !chord) |=> state_q == ST_CPV);

  // R8: a show state never advances past its own entry step
  a_r8_show_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPV && !chord) |=> (state_q == ST_SPV || state_q == ST_CPV));

  // R11: the result state holds until a reset chord
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RES && !chord) |=> state_q == ST_RES);

  // R12: undefined mode returns from the launch to ready
  a_r12_none_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GLO && mode == M_NONE && !chord) |=> state_q == ST_RDY);

endmodule

// File: rtl/calc_operand_bank.sv
module calc_operand_bank
  import calc_seq_pkg::*;
#(
  parameter int SWW = 10,
  parameter int OPW = 27,
  parameter int RW  = 7,
  parameter int YW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  cst_e           state,
  input  logic           ld_en,
  input  logic [2:0]     key,
  input  logic [SWW-1:0] sw,
  output mode_t          mode_o,
  output logic [OPW-1:0] fv_o,
  output logic [OPW-1:0] pv_o,
  output logic [RW-1:0]  rate_o,
  output logic [YW-1:0]  years_o
);

  localparam int TOPW = OPW - 2*SWW;

  // slice update of a wide operand, one slice per key
  function automatic logic [OPW-1:0] merge(logic [OPW-1:0] cur, logic [2:0] k,
                                           logic [SWW-1:0] s);
    logic [OPW-1:0] r;
    r = cur;
    if (k[0]) r[SWW-1:0]       = s;
    if (k[1]) r[2*SWW-1:SWW]   = s;
    if (k[2]) r[OPW-1:2*SWW]   = s[TOPW-1:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o  <= M_NONE;
      fv_o    <= '0;
      pv_o    <= '0;
      rate_o  <= RW'(1);
      years_o <= YW'(1);
    end else if (clr) begin
      mode_o  <= M_NONE;
      fv_o    <= '0;
      pv_o    <= '0;
      rate_o  <= RW'(1);
      years_o <= YW'(1);
    end else if (ld_en) begin
      case (state)
        ST_RDY:         if (key[0]) mode_o <= sw[1:0];
        ST_CFV, ST_SFV: fv_o <= merge(fv_o, key, sw);
        ST_CPV, ST_SPV: pv_o <= merge(pv_o, key, sw);
        ST_CRT, ST_SRT: if (key[0]) rate_o <= sw[RW-1:0];
        ST_CYR, ST_SYR: if (key[0]) years_o <= sw[YW-1:0];
        default: ;
      endcase
    end
  end

  // R1: the chord restores every operand default
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fv_o == '0 && pv_o == '0 && rate_o == RW'(1) &&
             years_o == YW'(1) && mode_o == M_NONE));

  // R7: rate changes only through key 0
  a_r7_rate_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CRT && !key[0] && !clr) |=> $stable(rate_o));

endmodule

// File: rtl/calc_launch.sv
module calc_launch
  import calc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cst_e  state_d,
  input  mode_t mode,
  output logic  start_fv_o,
  output logic  start_dt_o,
  output logic  start_rate_o
);

  logic lo_fv, lo_dt, lo_rate;

  always_comb begin
    lo_fv   = (state_d == ST_GLO) && (mode == M_FV);
    lo_dt   = (state_d == ST_GLO) && (mode == M_DT);
    lo_rate = (state_d == ST_GLO) && (mode == M_RATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_fv_o   <= 1'b1;
      start_dt_o   <= 1'b1;
      start_rate_o <= 1'b1;
    end else begin
      start_fv_o   <= ~lo_fv;
      start_dt_o   <= ~lo_dt;
      start_rate_o <= ~lo_rate;
    end
  end

  // R10: never more than one unit is being started
  a_r10_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({start_fv_o, start_dt_o, start_rate_o}) >= 2);

  // R10: a low start phase lasts a single cycle
  a_r10_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_fv_o || !start_dt_o || !start_rate_o) |=>
      (start_fv_o && start_dt_o && start_rate_o));

endmodule

// File: rtl/calc_disp_route.sv
module calc_disp_route
  import calc_seq_pkg::*;
(
  input  cst_e               state,
  input  mode_t              mode,
  input  logic               err,
  input  logic [4*DIGW-1:0]  res_dig,
  output logic [4*DIGW-1:0]  disp_o,
  output logic [2:0]         led_mode_o,
  output logic               led_dp_o,
  output logic               sys_rst_o
);

  always_comb begin
    case (state)
      ST_RST:                         disp_o = {4{C_BLANK}};
      ST_RDY:                         disp_o = prompt(state);
      ST_CFV, ST_CPV, ST_CRT, ST_CYR: disp_o = err ? res_dig : prompt(state);
      default:                        disp_o = res_dig;
    endcase
    case (mode)
      M_RATE:  led_mode_o = 3'b001;
      M_FV:    led_mode_o = 3'b010;
      M_DT:    led_mode_o = 3'b100;
      default: led_mode_o = 3'b000;
    endcase
    led_dp_o  = (state == ST_RES);
    sys_rst_o = (state == ST_RST);
  end

endmodule

// File: rtl/calc_seq_ctrl.sv
module calc_seq_ctrl
  import calc_seq_pkg::*;
#(
  parameter int SHOW_CYC = 25_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  sw_i,
  input  logic [3:0]  key_i,
  input  logic        err_i,
  input  logic [27:0] res_dig_i,
  output logic [1:0]  mode_o,
  output logic [26:0] fv_o,
  output logic [26:0] pv_o,
  output logic [6:0]  rate_o,
  output logic [5:0]  years_o,
  output logic        sys_rst_o,
  output logic        start_fv_o,
  output logic        start_dt_o,
  output logic        start_rate_o,
  output logic [2:0]  led_mode_o,
  output logic        led_dp_o,
  output logic [27:0] disp_o
);

  cst_e  st_q, st_d;
  logic  ld_en, chord;
  mode_t mode_w;

  calc_seq_fsm #(.SWW(10), .SHOW_CYC(SHOW_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sw(sw_i), .key(key_i), .mode(mode_w),
    .state_q(st_q), .state_d(st_d), .ld_en(ld_en), .chord(chord)
  );

  calc_operand_bank #(.SWW(10), .OPW(27), .RW(7), .YW(6)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(chord), .state(st_q), .ld_en(ld_en),
    .key(key_i[2:0]), .sw(sw_i), .mode_o(mode_w), .fv_o(fv_o), .pv_o(pv_o),
    .rate_o(rate_o), .years_o(years_o)
  );

  calc_launch u_launch (
    .clk(clk), .rst_n(rst_n), .state_d(st_d), .mode(mode_w),
    .start_fv_o(start_fv_o), .start_dt_o(start_dt_o), .start_rate_o(start_rate_o)
  );

  calc_disp_route u_disp (
    .state(st_q), .mode(mode_w), .err(err_i), .res_dig(res_dig_i),
    .disp_o(disp_o), .led_mode_o(led_mode_o), .led_dp_o(led_dp_o),
    .sys_rst_o(sys_rst_o)
  );

  assign mode_o = mode_w;

endmodule

// File: tb/sim_calc_seq_ctrl.sv
module sim_calc_seq_ctrl;

  localparam int SHOWN = 4;
  localparam logic [27:0] DIG   = {7'd11, 7'd22, 7'd33, 7'd44};
  localparam logic [27:0] BLANK = {4{7'd127}};
  localparam logic [27:0] P_RDY = {7'd22, 7'd0, 7'd13, 7'd14};
  localparam logic [27:0] P_FV  = {7'd8, 7'd37, 7'd15, 7'd30};
  localparam logic [27:0] P_PV  = {7'd7, 7'd37, 7'd25, 7'd30};
  localparam logic [27:0] P_RT  = {7'd6, 7'd37, 7'd18, 7'd23};
  localparam logic [27:0] P_YR  = {7'd5, 7'd37, 7'd34, 7'd27};
  localparam logic [2:0]  S_ID  = 3'b111;   // {fv, dt, rate}

  localparam int NROW = 28;
  // row: {sw, key, err, expected display, expected starts}
  localparam logic [45:0] TBL [NROW] = '{
    {10'h000, 4'b0000, 1'b0, P_RDY, S_ID},
    {10'h001, 4'b0001, 1'b0, P_RDY, S_ID},
    {10'h200, 4'b1000, 1'b0, P_FV,  S_ID},
    {10'h000, 4'b0000, 1'b0, P_PV,  S_ID},
    {10'h155, 4'b0001, 1'b0, DIG,   S_ID},
    {10'h0AA, 4'b0010, 1'b0, DIG,   S_ID},
    {10'h005, 4'b0100, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, P_PV,  S_ID},
    {10'h080, 4'b1000, 1'b0, P_RT,  S_ID},
    {10'h3E5, 4'b0001, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, P_RT,  S_ID},
    {10'h000, 4'b0000, 1'b1, DIG,   S_ID},
    {10'h040, 4'b1000, 1'b0, P_YR,  S_ID},
    {10'h3C3, 4'b0001, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, P_YR,  S_ID},
    {10'h020, 4'b1000, 1'b0, DIG,   3'b011},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h000, 4'b0000, 1'b0, DIG,   S_ID},
    {10'h3FF, 4'b1000, 1'b0, DIG,   S_ID}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  sw;
  logic [3:0]  key;
  logic        err;
  logic [27:0] res_dig;
  logic [1:0]  mode;
  logic [26:0] fv, pv;
  logic [6:0]  rate;
  logic [5:0]  years;
  logic        sys_rst, st_fv, st_dt, st_rate, led_dp;
  logic [2:0]  led_mode;
  logic [27:0] disp;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  calc_seq_ctrl #(.SHOW_CYC(SHOWN)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_i(sw), .key_i(key), .err_i(err),
    .res_dig_i(res_dig), .mode_o(mode), .fv_o(fv), .pv_o(pv), .rate_o(rate),
    .years_o(years), .sys_rst_o(sys_rst), .start_fv_o(st_fv),
    .start_dt_o(st_dt), .start_rate_o(st_rate), .led_mode_o(led_mode),
    .led_dp_o(led_dp), .disp_o(disp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] s, input logic [3:0] k, input logic e);
    @(negedge clk);
    sw = s; key = k; err = e;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_clear(input string tag);
    chk({tag, " sys_rst"}, 32'(sys_rst), 32'd1);
    chk({tag, " disp"}, 32'(disp), 32'(BLANK));
    chk({tag, " fv"}, 32'(fv), 32'd0);
    chk({tag, " pv"}, 32'(pv), 32'd0);
    chk({tag, " rate"}, 32'(rate), 32'd1);
    chk({tag, " years"}, 32'(years), 32'd1);
    chk({tag, " mode"}, 32'(mode), 32'd3);
    chk({tag, " leds"}, 32'({led_mode, led_dp}), 32'd0);
    chk({tag, " starts"}, 32'({st_fv, st_dt, st_rate}), 32'(S_ID));
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sw = '0; key = '0; err = 1'b0; res_dig = DIG;
    #23;
    chk_clear("R1 rst_n");
    @(negedge clk); rst_n = 1'b1;

    // main walk, mode 01: table of one-edge rows
    for (int i = 0; i < NROW; i++) begin
      step(TBL[i][45:36], TBL[i][35:32], TBL[i][31]);
      chk($sformatf("R4 R8 R9 R10 table row %0d disp", i), 32'(disp), 32'(TBL[i][30:3]));
      chk($sformatf("R10 table row %0d starts", i), 32'({st_fv, st_dt, st_rate}),
          32'(TBL[i][2:0]));
    end
    chk("R2 mode loaded", 32'(mode), 32'd1);
    chk("R3 led mode 01", 32'(led_mode), 32'b010);
    chk("R6 pv slices", 32'(pv), 32'({7'h05, 10'h0AA, 10'h155}));
    chk("R5 fv untouched in mode 01", 32'(fv), 32'd0);
    chk("R7 rate low bits", 32'(rate), 32'h65);
    chk("R7 years low bits", 32'(years), 32'h03);
    chk("R11 dp marker", 32'(led_dp), 32'd1);
    chk("R2 sys_rst released", 32'(sys_rst), 32'd0);

    // chord with switch 9 on has no effect
    step(10'h200, 4'b1111, 1'b0);
    chk("R1 chord sw9 on disp", 32'(disp), 32'(DIG));
    chk("R11 chord sw9 on dp", 32'(led_dp), 32'd1);
    step(10'h000, 4'b1111, 1'b0);
    chk_clear("R1 chord");
    step(10'h000, 4'b0000, 1'b0);
    chk("R2 ready prompt", 32'(disp), 32'(P_RDY));
    chk("R2 ready sys_rst", 32'(sys_rst), 32'd0);

    // mode 11 walks through and returns without any start
    step(10'h200, 4'b1000, 1'b0);
    chk("R12 fv prompt", 32'(disp), 32'(P_FV));
    for (int j = 0; j < 5; j++) begin
      step(10'h000, 4'b0000, 1'b0);
      chk("R12 no start", 32'({st_fv, st_dt, st_rate}), 32'(S_ID));
    end
    chk("R12 back to ready", 32'(disp), 32'(P_RDY));
    chk("R3 led mode 11", 32'(led_mode), 32'b000);

    // mode 10: only rate is entered
    step(10'h002, 4'b0001, 1'b0);
    chk("R3 led mode 10", 32'(led_mode), 32'b100);
    step(10'h200, 4'b1000, 1'b0);
    chk("R5 fv pass mode 10", 32'(disp), 32'(P_FV));
    step(10'h000, 4'b0000, 1'b0);
    chk("R5 pv pass mode 10", 32'(disp), 32'(P_PV));
    step(10'h000, 4'b0000, 1'b0);
    chk("R5 rate kept mode 10", 32'(disp), 32'(P_RT));
    step(10'h3FF, 4'b0010, 1'b0);
    chk("R7 key1 no show", 32'(disp), 32'(P_RT));
    chk("R7 key1 no load", 32'(rate), 32'd1);
    step(10'h3FF, 4'b0100, 1'b0);
    chk("R7 key2 no load", 32'(rate), 32'd1);
    step(10'h00A, 4'b0001, 1'b0);
    chk("R8 show after load", 32'(disp), 32'(DIG));
    chk("R7 rate loaded", 32'(rate), 32'd10);
    for (int j = 0; j < SHOWN - 1; j++) step(10'h000, 4'b0000, 1'b0);
    chk("R8 still showing", 32'(disp), 32'(DIG));
    step(10'h000, 4'b0000, 1'b0);
    chk("R8 back to prompt", 32'(disp), 32'(P_RT));
    step(10'h040, 4'b1000, 1'b0);
    chk("R5 years pass mode 10", 32'(disp), 32'(P_YR));
    step(10'h000, 4'b0000, 1'b0);
    chk("R10 dt low", 32'({st_fv, st_dt, st_rate}), 32'b101);
    step(10'h000, 4'b0000, 1'b0);
    chk("R10 dt high", 32'({st_fv, st_dt, st_rate}), 32'(S_ID));
    step(10'h000, 4'b0000, 1'b0);
    chk("R11 result dp", 32'(led_dp), 32'd1);

    // mode 00: future-value slices, advance ignored while showing
    step(10'h000, 4'b1111, 1'b0);
    step(10'h000, 4'b0000, 1'b0);
    step(10'h000, 4'b0001, 1'b0);
    chk("R3 led mode 00", 32'(led_mode), 32'b001);
    step(10'h200, 4'b1000, 1'b0);
    step(10'h000, 4'b0000, 1'b0);
    chk("R5 fv kept mode 00", 32'(disp), 32'(P_FV));
    step(10'h3FF, 4'b0001, 1'b0);
    step(10'h001, 4'b0010, 1'b0);
    step(10'h3FF, 4'b0100, 1'b0);
    chk("R6 fv slices", 32'(fv), 32'({7'h7F, 10'h001, 10'h3FF}));
    step(10'h100, 4'b1000, 1'b0);
    chk("R8 advance ignored", 32'(disp), 32'(DIG));
    step(10'h000, 4'b0000, 1'b0);
    step(10'h000, 4'b0000, 1'b0);
    chk("R8 showing count", 32'(disp), 32'(DIG));
    step(10'h000, 4'b0000, 1'b0);
    chk("R8 fv prompt again", 32'(disp), 32'(P_FV));
    step(10'h100, 4'b1000, 1'b0);
    chk("R4 fv to pv", 32'(disp), 32'(P_PV));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule